// File: doc/BRIEF.md
# Host Command and Status Register Block

This block is the host-side register window and command sequencer of a DMA network controller that sits on a 16-bit bus with byte addresses. It answers at a parameterised base address. That base holds four word slots: a control/status word, the low 16 bits of a buffer address, a transfer length, and an optional upper-address word that is present only when the wide-address option is built in. The control/status word carries several things: an extended-mode bit, a six-bit function code, a command-complete flag and its interrupt enable, a receive-complete flag and its interrupt enable, and a four-bit completion status.

Software issues a command by writing a non-zero function code. The block checks the code against the sparse set of supported commands. A supported code is handed to an external execution unit through a one-cycle start strobe. That unit later reports back with a done strobe and a status value. Codes outside the set complete at once with the illegal-command status. The reset command is carried out inside the block.

Completion events feed a two-source interrupt arbiter. Receive completion is signalled at the base vector and command completion at the base vector plus four. Each source stays pending until the host acknowledges it.

Top module: `nic_cmd_regs`

## Requirements
- R1: An access hits only when the address bits above bit 2 equal the base. Address bit 0 is ignored. Slot 6 hits only when the wide-address option is built. A miss returns zero read data.
- R2: A control/status read returns, from bit 15 down, the following: extended-mode (15), a zero (14), function code (13:8), command-complete (7), command interrupt enable (6), receive-complete (5), receive interrupt enable (4) and status (3:0). Reads of slots 2, 4 and 6 return zero.
- R3: Writing a supported code while idle does three things after the next clock edge: it clears command-complete, it raises cmd_start for exactly one cycle, and it shows the code on cmd_code. The supported octal codes are 01–07, 10–12, 15–17, 20–23, 30, 31, 40, 50–54 and 60; code 77 is also supported and is handled under R10.
- R4: A cmd_done strobe while a command is outstanding loads the 4-bit cmd_status into the status field and sets command-complete.
- R5: A non-zero unsupported code completes on the write edge with status 2 and command-complete set, and it gives no cmd_start. A function field of 00 issues no command.
- R6: While a command is outstanding, a newly written function field is ignored, and so is a cmd_done strobe that arrives while idle.
- R7: A completion with the command interrupt enable set makes a request pending at vector base+4. With the enable clear, no request is raised.
- R8: rx_done sets receive-complete, and it makes a request pending at the base vector if the receive enable is set. Writing 1 to bit 5 clears receive-complete. When both sources are pending, the base vector is presented first.
- R9: irq_req is high while any source is pending. irq_ack clears the source whose vector is being presented.
- R10: Code 77 clears the mode bit, both enables, receive-complete, every address and length word and all pending requests. It completes with status 0 and command-complete set, and it gives no cmd_start.
- R11: Writes to slots 2, 4 and 6 drive cmd_addr and cmd_count. Only the low 6 bits of the slot-6 word are kept, as cmd_addr bits 21:16.
- R12: After reset the control/status word reads zero and cmd_start and irq_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the current address |
| bus_hit | output | 1 | Address falls in this block |
| cmd_start | output | 1 | One-cycle start to the execution unit |
| cmd_code | output | 6 | Function code of the current command |
| cmd_addr | output | 16 or 16+XBAR_W | Buffer address |
| cmd_count | output | 16 | Transfer length |
| cmd_done | input | 1 | Execution unit has finished |
| cmd_status | input | 4 | Completion status from the execution unit |
| rx_done | input | 1 | Receive DMA finished |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | VEC_W | Vector of the presented request |
| irq_ack | input | 1 | Acknowledge of the presented request |

## Verification
The assertions assume that the execution unit raises cmd_done only for a command it was actually given. The bench's stand-in unit therefore strobes cmd_done only after it has seen cmd_start, with one deliberate exception: a single stray strobe sent while idle to exercise R6. The assertions also assume that bus_wr, rx_done and irq_ack are single-cycle strobes that are stable around the clock edge. The bench drives every one of them on the falling edge and drops it one cycle later.

// File: rtl/nic_cmd_pkg.sv
package nic_cmd_pkg;

   localparam int WORD_W = 16;
   localparam int FUNC_W = 6;
   localparam int STAT_W = 4;

   localparam logic [FUNC_W-1:0] FN_NONE  = 6'o00;
   localparam logic [FUNC_W-1:0] FN_RESET = 6'o77;

   localparam logic [STAT_W-1:0] ST_OK      = 4'd0;
   localparam logic [STAT_W-1:0] ST_ILLEGAL = 4'd2;

   // word slot inside the block's window
   typedef enum logic [1:0] {
      SLOT_CSR  = 2'd0,
      SLOT_ADDR = 2'd1,
      SLOT_LEN  = 2'd2,
      SLOT_XADR = 2'd3
   } reg_slot_e;

   // supported command set (sparse octal table)
   function automatic logic is_legal(input logic [FUNC_W-1:0] c);
      logic ok;
      case (c)
         6'o01, 6'o02, 6'o03, 6'o04, 6'o05, 6'o06, 6'o07,
         6'o10, 6'o11, 6'o12,
         6'o15, 6'o16, 6'o17,
         6'o20, 6'o21, 6'o22, 6'o23,
         6'o30, 6'o31,
         6'o40,
         6'o50, 6'o51, 6'o52, 6'o53, 6'o54,
         6'o60,
         6'o77:   ok = 1'b1;
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/nic_cmd_addr_dec.sv
module nic_cmd_addr_dec
   import nic_cmd_pkg::*;
#(
   parameter int                ADDR_W    = 18,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 18'o764000,
   parameter bit                EXT_ADDR  = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output reg_slot_e         slot
);

   localparam int TAG_LSB = 3;

   if (ADDR_W <= TAG_LSB) begin : g_bad_width
      $error("nic_cmd_addr_dec: ADDR_W too small");
   end
   if (BASE_ADDR[TAG_LSB-1:0] != '0) begin : g_bad_base
      $error("nic_cmd_addr_dec: base must be 8-byte aligned");
   end

   logic tag_match;
   logic unused_byte_lane;

   assign unused_byte_lane = addr[0];
   assign tag_match = (addr[ADDR_W-1:TAG_LSB] == BASE_ADDR[ADDR_W-1:TAG_LSB]);
   assign slot      = reg_slot_e'(addr[2:1]);

   if (EXT_ADDR) begin : g_wide
      assign hit = tag_match;
   end else begin : g_narrow
      assign hit = tag_match && (slot != SLOT_XADR);
   end

endmodule

// File: rtl/nic_cmd_seq.sv
module nic_cmd_seq
   import nic_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [FUNC_W-1:0] code,
   input  logic              cmd_done,
   input  logic [STAT_W-1:0] cmd_status,
   output logic              start,
   output logic              busy,
   output logic [FUNC_W-1:0] func,
   output logic [STAT_W-1:0] stat,
   output logic              cdn,
   output logic              done_evt,
   output logic              reset_evt
);

   logic take, legal, do_illegal, do_launch, do_finish;

   assign take       = issue && !busy;
   assign legal      = is_legal(code);
   assign reset_evt  = take && (code == FN_RESET);
   assign do_illegal = take && !legal;
   assign do_launch  = take && legal && (code != FN_RESET);
   assign do_finish  = busy && cmd_done;
   assign done_evt   = do_illegal || do_finish;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start <= 1'b0;
         busy  <= 1'b0;
         func  <= FN_NONE;
         stat  <= ST_OK;
         cdn   <= 1'b0;
      end else begin
         start <= 1'b0;
         if (reset_evt) begin
            func <= FN_RESET;
            stat <= ST_OK;
            cdn  <= 1'b1;
         end else if (do_illegal) begin
            func <= code;
            stat <= ST_ILLEGAL;
            cdn  <= 1'b1;
         end else if (do_launch) begin
            func  <= code;
            cdn   <= 1'b0;
            busy  <= 1'b1;
            start <= 1'b1;
         end
         if (do_finish) begin
            stat <= cmd_status;
            cdn  <= 1'b1;
            busy <= 1'b0;
         end
      end
   end

   // R3: the start strobe never lasts two cycles
   p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);

   // R4: completion from the execution unit is captured
   p_finish_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_done) |=> (cdn && !busy && stat == $past(cmd_status)));

   // R5: unsupported codes finish at once without a start
   p_illegal_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !busy && !is_legal(code)) |=> (cdn && stat == ST_ILLEGAL && !start));

   // R6: writes while outstanding leave the command alone
   p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && issue) |=> ($stable(func) && !start));

endmodule

// File: rtl/nic_irq_arb.sv
module nic_irq_arb #(
   parameter int               VEC_W    = 9,
   parameter logic [VEC_W-1:0] VEC_BASE = 9'o340
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             set_rx,
   input  logic             set_cmd,
   input  logic             ack,
   output logic             req,
   output logic [VEC_W-1:0] vec
);

   localparam logic [VEC_W-1:0] VEC_CMD = VEC_BASE + VEC_W'(4);

   if (VEC_BASE[1:0] != 2'b00) begin : g_bad_vec
      $error("nic_irq_arb: vector base must be a multiple of four");
   end

   logic pend_rx, pend_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_rx  <= 1'b0;
         pend_cmd <= 1'b0;
      end else if (clr_all) begin
         pend_rx  <= 1'b0;
         pend_cmd <= 1'b0;
      end else begin
         pend_rx  <= set_rx  || (pend_rx  && !ack);
         pend_cmd <= set_cmd || (pend_cmd && !(ack && !pend_rx));
      end
   end

   assign req = pend_rx || pend_cmd;
   assign vec = pend_rx ? VEC_BASE : VEC_CMD;

   // R8: a fresh receive event is presented first
   p_rx_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_rx && !clr_all) |=> (req && vec == VEC_BASE));

   // R9: acknowledging the only pending source drops the request
   p_ack_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && req && !(pend_rx && pend_cmd) && !set_rx && !set_cmd) |=> !req);

endmodule

// File: rtl/nic_cmd_regs.sv
module nic_cmd_regs
   import nic_cmd_pkg::*;
#(
   parameter int                ADDR_W    = 18,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 18'o764000,
   parameter int                VEC_W     = 9,
   parameter logic [VEC_W-1:0]  VEC_BASE  = 9'o340,
   parameter bit                EXT_ADDR  = 1'b1,
   parameter int                XBAR_W    = 6
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic [ADDR_W-1:0]                          bus_addr,
   input  logic                                       bus_wr,
   input  logic [15:0]                                bus_wdata,
   output logic [15:0]                                bus_rdata,
   output logic                                       bus_hit,
   output logic                                       cmd_start,
   output logic [5:0]                                 cmd_code,
   output logic [(EXT_ADDR ? 16 + XBAR_W : 16)-1:0]   cmd_addr,
   output logic [15:0]                                cmd_count,
   input  logic                                       cmd_done,
   input  logic [3:0]                                 cmd_status,
   input  logic                                       rx_done,
   output logic                                       irq_req,
   output logic [VEC_W-1:0]                           irq_vec,
   input  logic                                       irq_ack
);

   // control word bit map
   localparam int B_XM  = 15;
   localparam int B_FHI = 13;
   localparam int B_FLO = 8;
   localparam int B_CDN = 7;
   localparam int B_CIE = 6;
   localparam int B_RDN = 5;
   localparam int B_RIE = 4;

   if (XBAR_W < 1 || XBAR_W > WORD_W) begin : g_bad_xbar
      $error("nic_cmd_regs: XBAR_W out of range");
   end
   if (B_FHI - B_FLO + 1 != FUNC_W) begin : g_bad_map
      $error("nic_cmd_regs: function field width mismatch");
   end

   reg_slot_e         slot;
   logic              csr_wr, addr_wr, len_wr, xadr_wr, issue;
   logic              xm_q, cie_q, rie_q, rdn_q;
   logic              cie_eff, rie_eff;
   logic [WORD_W-1:0] bar_q, bcr_q;
   logic              busy, cdn, done_evt, reset_evt;
   logic [FUNC_W-1:0] func;
   logic [STAT_W-1:0] stat;
   logic [WORD_W-1:0] csr_word;

   nic_cmd_addr_dec #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .EXT_ADDR  (EXT_ADDR)
   ) u_dec (
      .addr (bus_addr),
      .hit  (bus_hit),
      .slot (slot)
   );

   assign csr_wr  = bus_wr && bus_hit && (slot == SLOT_CSR);
   assign addr_wr = bus_wr && bus_hit && (slot == SLOT_ADDR);
   assign len_wr  = bus_wr && bus_hit && (slot == SLOT_LEN);
   assign xadr_wr = bus_wr && bus_hit && (slot == SLOT_XADR);
   assign issue   = csr_wr && (bus_wdata[B_FHI:B_FLO] != FN_NONE);

   nic_cmd_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .code       (bus_wdata[B_FHI:B_FLO]),
      .cmd_done   (cmd_done),
      .cmd_status (cmd_status),
      .start      (cmd_start),
      .busy       (busy),
      .func       (func),
      .stat       (stat),
      .cdn        (cdn),
      .done_evt   (done_evt),
      .reset_evt  (reset_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xm_q  <= 1'b0;
         cie_q <= 1'b0;
         rie_q <= 1'b0;
         rdn_q <= 1'b0;
         bar_q <= '0;
         bcr_q <= '0;
      end else if (reset_evt) begin
         xm_q  <= 1'b0;
         cie_q <= 1'b0;
         rie_q <= 1'b0;
         rdn_q <= 1'b0;
         bar_q <= '0;
         bcr_q <= '0;
      end else begin
         if (csr_wr) begin
            xm_q  <= bus_wdata[B_XM];
            cie_q <= bus_wdata[B_CIE];
            rie_q <= bus_wdata[B_RIE];
         end
         if (rx_done)
            rdn_q <= 1'b1;
         else if (csr_wr && bus_wdata[B_RDN])
            rdn_q <= 1'b0;
         if (addr_wr) bar_q <= bus_wdata;
         if (len_wr)  bcr_q <= bus_wdata;
      end
   end

   if (EXT_ADDR) begin : g_xadr
      logic [XBAR_W-1:0] xbar_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          xbar_q <= '0;
         else if (reset_evt)  xbar_q <= '0;
         else if (xadr_wr)    xbar_q <= bus_wdata[XBAR_W-1:0];
      end
      assign cmd_addr = {xbar_q, bar_q};
   end else begin : g_no_xadr
      assign cmd_addr = bar_q;
   end

   assign cmd_code  = func;
   assign cmd_count = bcr_q;

   // an enable written in the same cycle as an event already applies
   assign cie_eff = csr_wr ? bus_wdata[B_CIE] : cie_q;
   assign rie_eff = csr_wr ? bus_wdata[B_RIE] : rie_q;

   nic_irq_arb #(
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_all (reset_evt),
      .set_rx  (rx_done && rie_eff),
      .set_cmd (done_evt && cie_eff),
      .ack     (irq_ack),
      .req     (irq_req),
      .vec     (irq_vec)
   );

   assign csr_word = {xm_q, 1'b0, func, cdn, cie_q, rdn_q, rie_q, stat};
   assign bus_rdata = (bus_hit && slot == SLOT_CSR) ? csr_word : '0;

   // R3: an active start always coincides with a cleared complete flag
   p_start_clears_cdn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |-> (!cdn && busy));

   // R8: a receive event leaves the complete flag set
   p_rx_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !reset_evt) |=> rdn_q);

   // R10: the reset command leaves nothing enabled, stored or pending
   p_reset_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reset_evt |=> (!cie_q && !rie_q && !xm_q && cmd_addr == '0 &&
                     cmd_count == '0 && !irq_req && cdn && !cmd_start));

endmodule

// File: tb/nic_cmd_regs_tb.sv
module nic_cmd_regs_tb;

   localparam int          CLK_PERIOD = 10;
   localparam logic [17:0] BASE       = 18'o764000;
   localparam int          NVEC       = 18;

   // {code, supported, status the stand-in unit returns}
   localparam logic [10:0] TBL [NVEC] = '{
      {6'o01, 1'b1, 4'd0}, {6'o07, 1'b1, 4'd1}, {6'o10, 1'b1, 4'd0},
      {6'o12, 1'b1, 4'd4}, {6'o13, 1'b0, 4'd0}, {6'o14, 1'b0, 4'd0},
      {6'o17, 1'b1, 4'd0}, {6'o24, 1'b0, 4'd0}, {6'o30, 1'b1, 4'd0},
      {6'o31, 1'b1, 4'd3}, {6'o40, 1'b1, 4'd0}, {6'o41, 1'b0, 4'd0},
      {6'o54, 1'b1, 4'd5}, {6'o55, 1'b0, 4'd0}, {6'o60, 1'b1, 4'hF},
      {6'o76, 1'b0, 4'd0}, {6'o22, 1'b1, 4'd0}, {6'o32, 1'b0, 4'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [17:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_hit;
   logic        cmd_start;
   logic [5:0]  cmd_code;
   logic [21:0] cmd_addr;
   logic [15:0] cmd_count;
   logic        cmd_done = 1'b0;
   logic [3:0]  cmd_status = '0;
   logic        rx_done = 1'b0;
   logic        irq_req;
   logic [8:0]  irq_vec;
   logic        irq_ack = 1'b0;

   int vectors = 0;
   int miscompares = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nic_cmd_regs u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_hit    (bus_hit),
      .cmd_start  (cmd_start),
      .cmd_code   (cmd_code),
      .cmd_addr   (cmd_addr),
      .cmd_count  (cmd_count),
      .cmd_done   (cmd_done),
      .cmd_status (cmd_status),
      .rx_done    (rx_done),
      .irq_req    (irq_req),
      .irq_vec    (irq_vec),
      .irq_ack    (irq_ack)
   );

   function automatic logic [15:0] csrv(input logic xm, input logic [5:0] f,
                                        input logic cdn, input logic cie,
                                        input logic rdn, input logic rie,
                                        input logic [3:0] st);
      return {xm, 1'b0, f, cdn, cie, rdn, rie, st};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [17:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input logic [17:0] a, output logic [15:0] d, output logic h);
      bus_wr   = 1'b0;
      bus_addr = a;
      #1;
      d = bus_rdata;
      h = bus_hit;
   endtask

   task automatic finish_cmd(input logic [3:0] st);
      cmd_done   = 1'b1;
      cmd_status = st;
      @(negedge clk);
      cmd_done   = 1'b0;
   endtask

   task automatic pulse_rx();
      rx_done = 1'b1;
      @(negedge clk);
      rx_done = 1'b0;
   endtask

   task automatic pulse_ack();
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic        h;
      logic [5:0]  c;
      logic        lg;
      logic [3:0]  st;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R12: reset state
      rd(BASE, d, h);
      check("R12 csr after reset", d, 16'h0000);
      check("R12 start low", cmd_start, 1'b0);
      check("R12 irq low", irq_req, 1'b0);

      // R1: address decode
      rd(BASE + 18'o10, d, h);
      check("R1 next window misses", h, 1'b0);
      check("R1 miss reads zero", d, 16'h0000);
      rd(18'o754000, d, h);
      check("R1 other base misses", h, 1'b0);
      rd(BASE + 18'o1, d, h);
      check("R1 odd byte of csr hits", h, 1'b1);
      rd(BASE + 18'o6, d, h);
      check("R1 slot 6 hits when wide", h, 1'b1);

      // R11 and R2: address / length words, which read back as zero
      wr(BASE + 18'o2, 16'h1234);
      wr(BASE + 18'o6, 16'hFFC5);
      wr(BASE + 18'o4, 16'h00AA);
      check("R11 cmd_addr", cmd_addr, 22'h051234);
      check("R11 cmd_count", cmd_count, 16'h00AA);
      rd(BASE + 18'o2, d, h);
      check("R2 slot 2 reads zero", d, 16'h0000);
      rd(BASE + 18'o4, d, h);
      check("R2 slot 4 reads zero", d, 16'h0000);
      rd(BASE + 18'o6, d, h);
      check("R2 slot 6 reads zero", d, 16'h0000);

      // R3 R4 R5: walk the code table
      for (int i = 0; i < NVEC; i++) begin
         c  = TBL[i][10:5];
         lg = TBL[i][4];
         st = TBL[i][3:0];
         wr(BASE, csrv(1'b0, c, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0));
         check("R3 start follows support", cmd_start, lg);
         rd(BASE, d, h);
         if (lg) begin
            check("R3 complete flag cleared", d[7], 1'b0);
            check("R3 code shown", cmd_code, c);
            @(negedge clk);
            check("R3 start is one cycle", cmd_start, 1'b0);
            finish_cmd(st);
            rd(BASE, d, h);
            check("R4 status captured", d, csrv(1'b0, c, 1'b1, 1'b0, 1'b0, 1'b0, st));
         end else begin
            check("R5 illegal completes", d, csrv(1'b0, c, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2));
         end
         check("R7 no irq with enable clear", irq_req, 1'b0);
      end

      // R5: function field 00 issues nothing
      wr(BASE, csrv(1'b0, 6'o00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0));
      check("R5 code 00 no start", cmd_start, 1'b0);
      rd(BASE, d, h);
      check("R5 code 00 keeps state", d, csrv(1'b0, 6'o32, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2));

      // R6: busy ignores a new code, idle ignores stray done
      wr(BASE, csrv(1'b0, 6'o01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0));
      @(negedge clk);
      wr(BASE, csrv(1'b0, 6'o12, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0));
      check("R6 no restart while busy", cmd_start, 1'b0);
      check("R6 code kept while busy", cmd_code, 6'o01);
      finish_cmd(4'd3);
      rd(BASE, d, h);
      check("R6 original command finishes", d, csrv(1'b0, 6'o01, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
      finish_cmd(4'd4);
      rd(BASE, d, h);
      check("R6 stray done ignored", d, csrv(1'b0, 6'o01, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));

      // R10: reset command
      wr(BASE + 18'o2, 16'hBEEF);
      wr(BASE + 18'o4, 16'h0102);
      wr(BASE + 18'o6, 16'h003F);
      wr(BASE, csrv(1'b1, 6'o00, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0));
      pulse_rx();
      check("R8 rx request raised", irq_req, 1'b1);
      check("R8 rx vector", irq_vec, 9'o340);
      wr(BASE, csrv(1'b0, 6'o77, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0));
      check("R10 no start", cmd_start, 1'b0);
      rd(BASE, d, h);
      check("R10 csr after reset command", d, 16'h3F80);
      check("R10 address cleared", cmd_addr, 22'h0);
      check("R10 count cleared", cmd_count, 16'h0);
      check("R10 pending cleared", irq_req, 1'b0);

      // R2: bit positions of the control word
      wr(BASE, csrv(1'b1, 6'o00, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0));
      rd(BASE, d, h);
      check("R2 control word layout", d, 16'hBFD0);

      // R7 R9: command interrupt
      wr(BASE, csrv(1'b1, 6'o01, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0));
      check("R7 start with enable", cmd_start, 1'b1);
      @(negedge clk);
      finish_cmd(4'd0);
      check("R7 command request", irq_req, 1'b1);
      check("R7 command vector", irq_vec, 9'o344);
      pulse_ack();
      check("R9 ack drops request", irq_req, 1'b0);

      // R8 R9: receive interrupt, priority, flag clear
      pulse_rx();
      rd(BASE, d, h);
      check("R8 receive flag set", d[5], 1'b1);
      wr(BASE, csrv(1'b1, 6'o13, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0));
      check("R8 both pending rx first", irq_vec, 9'o340);
      pulse_ack();
      check("R9 cmd still pending", irq_req, 1'b1);
      check("R9 cmd vector next", irq_vec, 9'o344);
      pulse_ack();
      check("R9 all acknowledged", irq_req, 1'b0);
      wr(BASE, csrv(1'b1, 6'o00, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0));
      rd(BASE, d, h);
      check("R8 write one clears flag", d[5], 1'b0);
      check("R8 clear raises nothing", irq_req, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule